// File: doc/BRIEF.md
# Reloadable Pulse-Width Timer with 16-bit and 8-bit Modes

This block is one timer channel that drives a continuous pulse-width-modulated waveform on a single output. Software writes a data word, which holds the pulse width and, in the split mode, a prescale factor. It also writes a mode byte that selects the modulator length, the start source and the active trigger edge. A level input acts as the count-start bit. A count-enable input marks the cycles on which the selected count clock ticks. Once modulation is running, the waveform repeats with a fixed period until the start bit is cleared.

In the full-width mode the whole counter forms one modulator with a period of 65535 ticks. In the split mode the upper byte is the modulator, with a period of 255 steps. The lower byte is a prescaler that stretches each step to n+1 ticks. A new width written while the timer runs is held in the reload register. It is moved into the working counter at the start of the next period, so the pulse that is in progress is never cut short. An interrupt-request pulse marks every falling edge of the output.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset `pwm_out` and `irq` are 0. `rd_data` reads as all zeros at all times.
- R2: The timer can start only when mode bits [2:0] are all 1. With any other value it stays halted and the output stays low.
- R3: With mode bit 4 = 0 (software start), the first clock edge that sees `run` = 1 starts the timer. In the cycle after that edge, `pwm_out` is 1 when the width is nonzero.
- R4: With mode bit 4 = 1, the timer starts on an edge of `trig` while `run` = 1. Bit 3 = 1 selects a rising edge and bit 3 = 0 selects a falling edge. The opposite edge does not start the timer. The start happens on the clock edge that first samples the new `trig` level, and `pwm_out` is high in the next cycle.
- R5: While the timer runs, edges on `trig` have no effect on the waveform.
- R6: A data write while the timer is halted loads both the reload register and the working counter. A data write while it runs loads only the reload register, and the new width applies from the next period start.
- R7: With mode bit 5 = 0 and width m = `data_in`, the output is high for m ticks of every 65535-tick period. The output rises again at the period boundary.
- R8: With mode bit 5 = 1, m = `data_in[15:8]` and n = `data_in[7:0]`, the output is high for m·(n+1) ticks of every 255·(n+1)-tick period. A value m = 255 keeps the output permanently high.
- R9: `irq` is a one-cycle pulse in the first low cycle after a high phase while the timer runs. It never fires when the timer is halted.
- R10: Clearing `run` halts the timer, and `pwm_out` is 0 from the next cycle.
- R11: Counting advances only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Data word write strobe |
| data_in | input | 16 | Width (and prescale) value |
| mode_we | input | 1 | Mode byte write strobe |
| mode_in | input | 8 | Mode byte |
| run | input | 1 | Count-start level |
| tick | input | 1 | Count clock enable |
| trig | input | 1 | External start trigger |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Pulse on each output fall |
| rd_data | output | 16 | Timer readback (always zero) |

## Verification
Each start is registered once. The first cycle of the waveform is therefore due one clock after the edge that sees `run`, or one clock after the edge that first samples the new `trig` level. From that cycle on, each tick moves the output by exactly one sample. The bench samples on falling clock edges, starting with the first sample after the starting edge. For each start it counts high samples and `irq` pulses over a window of exactly one period, then checks that the output rises again in the sample that follows. A halt is checked in the very next sample. A width written while running is checked by counting over the rest of the current period and then over the whole next period.

// File: rtl/pwm_reload_timer.sv
`timescale 1ns/1ps
module pwm_reload_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_we,
  input  logic [W-1:0] data_in,
  input  logic         mode_we,
  input  logic [7:0]   mode_in,
  input  logic         run,
  input  logic         tick,
  input  logic         trig,
  output logic         pwm_out,
  output logic         irq,
  output logic [W-1:0] rd_data
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LAST_F = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] LAST_H = {{H{1'b0}}, {(H-1){1'b1}}, 1'b0};

  logic [7:0]   mode;
  logic [W-1:0] rl, cnt, ph;
  logic [H-1:0] pre;
  logic         active, trig_q, out_q;

  wire pwm_ok   = &mode[2:0];
  wire half     = mode[5];
  wire ext      = mode[4];
  wire edge_hit = mode[3] ? (trig & ~trig_q) : (~trig & trig_q);
  wire go       = run & pwm_ok & ~active & (~ext | edge_hit);
  wire [W-1:0] last  = half ? LAST_H : LAST_F;
  wire [W-1:0] width = half ? {{H{1'b0}}, cnt[W-1:H]} : cnt;

  assign pwm_out = active & (ph < width);
  assign irq     = out_q & ~pwm_out & active;
  assign rd_data = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; rl <= '0; cnt <= '0; ph <= '0; pre <= '0;
      active <= 1'b0; trig_q <= 1'b0; out_q <= 1'b0;
    end else begin
      trig_q <= trig;
      out_q  <= pwm_out;
      if (mode_we) mode <= mode_in;
      if (data_we) begin
        rl <= data_in;
        if (!active) cnt <= data_in;
      end
      if (!run || !pwm_ok) begin
        active <= 1'b0;
      end else if (!active) begin
        if (go) begin
          active <= 1'b1;
          ph     <= '0;
          pre    <= cnt[H-1:0];
        end
      end else if (tick) begin
        if (half && pre != '0) begin
          pre <= pre - 1'b1;
        end else if (ph >= last) begin
          ph  <= '0;
          cnt <= rl;
          pre <= rl[H-1:0];
        end else begin
          ph  <= ph + 1'b1;
          pre <= cnt[H-1:0];
        end
      end
    end
  end

  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_out);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!pwm_out && run && pwm_ok));
  a_r3_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (ph == '0));
  a_r6_halted_load: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !active) |=> (cnt == $past(data_in)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run && pwm_ok && !tick && !mode_we) |=> ($stable(ph) && $stable(pre)));
  a_r7_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ph <= LAST_F));
endmodule

// File: tb/pwm_reload_timer_bench.sv
`timescale 1ns/1ps
module pwm_reload_timer_bench;
  logic clk = 0, rst_n = 0, data_we = 0, mode_we = 0, run = 0, tick = 1, trig = 0;
  logic [15:0] data_in = '0;
  logic [7:0]  mode_in = '0;
  logic pwm_out, irq;
  logic [15:0] rd_data;
  logic alt = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always @(negedge clk) tick <= alt ? ~tick : 1'b1;

  pwm_reload_timer u_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_in(data_in),
    .mode_we(mode_we), .mode_in(mode_in), .run(run), .tick(tick), .trig(trig),
    .pwm_out(pwm_out), .irq(irq), .rd_data(rd_data));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] m);
    mode_in = m; mode_we = 1; @(negedge clk); mode_we = 0;
  endtask

  task automatic set_data(input logic [15:0] d);
    data_in = d; data_we = 1; @(negedge clk); data_we = 0;
  endtask

  task automatic halt();
    run = 0; @(negedge clk); @(negedge clk);
  endtask

  task automatic window(input int n, input int poke, output int hi, output int irqs);
    hi = 0; irqs = 0;
    for (int k = 0; k < n; k++) begin
      hi += int'(pwm_out);
      irqs += int'(irq);
      if (k == poke || k == poke + 1) trig = ~trig;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi, ir, expect_hi, per;
    int ms[6] = '{0, 1, 7, 128, 254, 255};
    @(negedge clk); @(negedge clk);
    chk("R1 reset pwm_out", int'(pwm_out), 0);
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data zero", int'(rd_data), 0);

    // R8 sweep in 8-bit mode, software start
    set_mode(8'h27);
    for (int mi = 0; mi < 6; mi++) begin
      for (int n = 0; n < 3; n++) begin
        set_data(16'((ms[mi] << 8) | n));
        run = 1; @(negedge clk);
        chk("R3 first sample", int'(pwm_out), int'(ms[mi] > 0));
        per = 255 * (n + 1);
        window(per, -5, hi, ir);
        chk("R8 high time", hi, ms[mi] * (n + 1));
        chk("R9 irq count", ir, (ms[mi] > 0 && ms[mi] < 255) ? 1 : 0);
        chk("R8 period rise", int'(pwm_out), int'(ms[mi] > 0));
        halt();
      end
    end

    // R6 running write takes effect at next period
    set_data(16'h0A00);
    run = 1; @(negedge clk);
    window(21, -5, hi, ir);
    chk("R6 before write", hi, 10);
    set_data(16'h3200);
    window(233, -5, hi, ir);
    chk("R6 current period kept", hi, 0);
    window(255, -5, hi, ir);
    chk("R6 new width next period", hi, 50);
    chk("R6 rd_data zero", int'(rd_data), 0);

    // R10 halt
    run = 0; @(negedge clk);
    window(10, -5, hi, ir);
    chk("R10 halted low", hi, 0);
    chk("R9 no irq on halt", ir, 0);
    halt();

    // R10 halt mid high phase
    set_data(16'hC800);
    run = 1; @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R10 high before halt", int'(pwm_out), 1);
    run = 0; @(negedge clk);
    chk("R10 low after halt", int'(pwm_out), 0);
    chk("R9 no irq at halt", int'(irq), 0);
    halt();

    // R2 non-PWM mode
    set_mode(8'h23);
    set_data(16'h0A00);
    run = 1; @(negedge clk);
    window(300, -5, hi, ir);
    chk("R2 no start", hi, 0);
    halt();

    // R4 rising edge trigger; R5 mid-run trigger ignored
    set_mode(8'h3F);
    trig = 1; set_data(16'h0A00);
    run = 1; @(negedge clk);
    trig = 0;
    window(5, -5, hi, ir);
    chk("R4 falling edge ignored in rising mode", hi, 0);
    trig = 1; @(negedge clk);
    chk("R4 rising start", int'(pwm_out), 1);
    window(255, 4, hi, ir);
    chk("R5 trigger ignored high time", hi, 10);
    chk("R5 irq count", ir, 1);
    chk("R5 period rise", int'(pwm_out), 1);
    halt();

    // R4 falling edge trigger
    set_mode(8'h37);
    trig = 0; @(negedge clk);
    run = 1; @(negedge clk);
    trig = 1;
    window(5, -5, hi, ir);
    chk("R4 rising edge ignored in falling mode", hi, 0);
    trig = 0; @(negedge clk);
    chk("R4 falling start", int'(pwm_out), 1);
    window(255, 20, hi, ir);
    chk("R4 falling high time", hi, 10);
    halt();

    // R4 trigger without run
    trig = 1; @(negedge clk); trig = 0; @(negedge clk);
    window(5, -5, hi, ir);
    chk("R4 no start without run", hi, 0);

    // R11 gated ticks
    set_mode(8'h27);
    set_data(16'h0400);
    alt = 1;
    run = 1; @(negedge clk);
    window(510, -5, hi, ir);
    chk("R11 gated high time", hi, 8);
    chk("R11 gated irq", ir, 1);
    halt();
    alt = 0; @(negedge clk);

    // R7 16-bit mode
    set_mode(8'h07);
    set_data(16'd300);
    run = 1; @(negedge clk);
    chk("R7 first sample", int'(pwm_out), 1);
    window(65535, -5, hi, ir);
    expect_hi = 300;
    chk("R7 high time", hi, expect_hi);
    chk("R9 irq 16-bit", ir, 1);
    chk("R7 period rise", int'(pwm_out), 1);
    halt();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3_900_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule